// File: doc/BRIEF.md
# Asynchronous SRAM Host Controller

This block sits between a simple synchronous host request port and the pins of an external asynchronous static RAM organised as 128K words of 16 bits. The host presents one request at a time: a read or write flag, a word address, write data and a two-bit byte mask. It accepts the request when `req_valid` and `req_ready` are both high. For each accepted request the block returns a one-cycle `rsp_done` pulse and, for a read, the captured word.

On the memory side, every phase of the access lasts a fixed number of clock cycles. Each count is worked out when the block is built: the nanosecond limit is divided by the clock period, rounded up, and one margin cycle is added. A write first selects the chip with write-enable high. It then holds write-enable low for the pulse count, raises it to close the write, and keeps the chip selected for one more cycle before releasing it.

A read holds write-enable high, lowers output-enable for the access count and samples the data on the last of those cycles. A turnaround wait follows every read, so the data drivers cannot switch on while the memory may still be driving the bus. The address moves only on the cycle a request is accepted.

Top module: `sram_host_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_done` is 0. `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are 1, while `mem_ce` and `mem_dq_oe` are 0.
- R2: In a write, mask bit 0 enables the low byte, which is data bits 7:0 driven through `mem_lb_n`. Mask bit 1 enables the high byte, which is bits 15:8 driven through `mem_ub_n`. Only the enabled bytes of the addressed word change, and a later read returns the merged word.
- R3: In a write, `mem_we_n` stays low for exactly ceil(max(T_WP_NS, T_AW_NS, T_DW_NS) / CLK_NS) + 1 cycles, which is 14 with the defaults. `mem_dq_oe` is 1 whenever `mem_we_n` is low, and `mem_we_n` is never low while the chip is deselected.
- R4: `mem_addr` changes only on a cycle that follows a cycle with the chip deselected. It never changes while `mem_we_n` is low.
- R5: In a read, `mem_oe_n` stays low for exactly ceil(T_RC_NS / CLK_NS) + 1 cycles, which is 15 with the defaults. During those cycles `mem_we_n` is 1, both byte selects are 0 and `mem_addr` carries the requested address. `rsp_rdata` holds the word the memory presents on the last of those cycles.
- R6: After `mem_oe_n` rises at the end of a read, `mem_dq_oe` stays 0 for at least ceil(T_HZ_NS / CLK_NS) + 1 cycles, which is 6 with the defaults.
- R7: A write whose byte mask is 00 completes with a `rsp_done` pulse. It never lowers `mem_we_n` or selects the chip, and the memory contents do not change.
- R8: `rsp_done` is high for exactly one cycle per accepted request. `req_ready` is 0 whenever the chip is selected.
- R9: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = low byte |
| req_ready | output | 1 | Controller can accept a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read word |
| mem_addr | output | 17 | Memory address pins |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pin drivers |
| mem_dq_in | input | 16 | Data received from the memory pins |
| mem_ce_n | output | 1 | Low-active chip enable |
| mem_ce | output | 1 | High-active chip enable |
| mem_oe_n | output | 1 | Low-active output enable |
| mem_we_n | output | 1 | Low-active write enable |
| mem_lb_n | output | 1 | Low-active low byte select |
| mem_ub_n | output | 1 | Low-active high byte select |

## Verification
The bench runs sixteen addresses, each chosen with a distinct low byte and varied high bits. The memory is first read in its initial state, which shows that the access length and data capture are right. For each address the bench then writes, reads the same address back at once, and moves on to the next write. This alternation exercises the write-to-read switch and the read-to-write turnaround.

The byte masks cycle through 00, 01, 10 and 11, so a lane-swap, a lost lane and an unwanted strobe each give a different merged word. A final read-back sweep confirms that the results persist. Pin monitors time the width of every write-enable and output-enable pulse and the gap before the drivers switch on. They also watch for address movement while the chip is selected and for a repeated done pulse.

// File: rtl/sram_host_ctrl.sv
module sram_host_ctrl #(
  parameter int CLK_NS  = 4,
  parameter int T_RC_NS = 55,
  parameter int T_WP_NS = 45,
  parameter int T_AW_NS = 50,
  parameter int T_DW_NS = 25,
  parameter int T_HZ_NS = 20,
  parameter int AW      = 17,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n
);

  localparam int WR_A   = (T_WP_NS > T_AW_NS) ? T_WP_NS : T_AW_NS;
  localparam int WR_NS  = (WR_A > T_DW_NS) ? WR_A : T_DW_NS;
  localparam int RD_CYC = (T_RC_NS + CLK_NS - 1) / CLK_NS + 1;
  localparam int WP_CYC = (WR_NS + CLK_NS - 1) / CLK_NS + 1;
  localparam int TA_CYC = (T_HZ_NS + CLK_NS - 1) / CLK_NS + 1;
  localparam int MX_A   = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int MX_CYC = (MX_A > TA_CYC) ? MX_A : TA_CYC;
  localparam int CW     = $clog2(MX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TA, S_WSU, S_WPL, S_WHD} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [1:0]    be_q;
  logic          done_q;
  logic          sel, wr_ph, last;

  assign sel   = (state == S_RD) || wr_ph;
  assign wr_ph = (state == S_WSU) || (state == S_WPL) || (state == S_WHD);
  assign last  = (cnt == CW'(1));

  assign req_ready  = (state == S_IDLE) && !done_q;
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = wr_ph;
  assign mem_ce_n   = !sel;
  assign mem_ce     = sel;
  assign mem_oe_n   = (state != S_RD);
  assign mem_we_n   = (state != S_WPL);
  assign mem_lb_n   = !((state == S_RD) || (wr_ph && be_q[0]));
  assign mem_ub_n   = !((state == S_RD) || (wr_ph && be_q[1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      be_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (req_valid && req_ready) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          if (!req_write) begin
            state <= S_RD;
            cnt   <= CW'(RD_CYC);
          end else if (req_be == 2'b00) begin
            done_q <= 1'b1;
          end else begin
            state <= S_WSU;
          end
        end
        S_RD: if (last) begin
          rdata_q <= mem_dq_in;
          done_q  <= 1'b1;
          state   <= S_TA;
          cnt     <= CW'(TA_CYC);
        end else cnt <= cnt - CW'(1);
        S_TA: if (last) state <= S_IDLE;
              else cnt <= cnt - CW'(1);
        S_WSU: begin
          state <= S_WPL;
          cnt   <= CW'(WP_CYC);
        end
        S_WPL: if (last) state <= S_WHD;
               else cnt <= cnt - CW'(1);
        S_WHD: begin
          state  <= S_IDLE;
          done_q <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_we_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_ce_n && mem_ce));
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));
  p_read_we_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);
  p_single_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);
  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

endmodule

// File: tb/sram_host_ctrl_bench.sv
`timescale 1ns/1ps
module sram_host_ctrl_bench;
  localparam int CLK_NS = 4;
  localparam int WP_EXP = (50 + CLK_NS - 1) / CLK_NS + 1;
  localparam int RD_EXP = (55 + CLK_NS - 1) / CLK_NS + 1;
  localparam int TA_EXP = (20 + CLK_NS - 1) / CLK_NS + 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_done, mem_dq_oe, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [16:0] mem_addr;

  always #2 clk = ~clk;

  sram_host_ctrl u_sram_host_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n));

  logic [15:0] mdl [256];
  logic [15:0] expv [256];
  int tests = 0, fails = 0;
  int drv_bad = 0, we_falls = 0, sel_falls = 0;
  int we_run = 0, oe_run = 0, ta_since = 1000;
  int addr_bad = 0, done_bad = 0, ready_bad = 0, cont_bad = 0;
  logic after_read = 0;
  logic p_we = 1, p_ce_n = 1, p_done = 0, p_dq_oe = 0;
  logic [16:0] p_addr = '0, seen_addr = '0;
  logic finished = 0;

  assign mem_dq_in = (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n) ? mdl[mem_addr[7:0]] : 16'h0000;

  always @(posedge mem_we_n) begin
    if (!mem_ce_n && mem_ce) begin
      if (!mem_dq_oe) drv_bad++;
      if (!mem_lb_n) mdl[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) mdl[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expd);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expd);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n) we_run++;
    else if (we_run > 0) begin
      check(we_run == WP_EXP, "R3 we_n low width", we_run, WP_EXP);
      we_run = 0;
    end
    if (!mem_oe_n) begin
      oe_run++; ta_since = 0; after_read = 1; seen_addr = mem_addr;
      if (!mem_we_n || mem_lb_n || mem_ub_n) cont_bad++;
    end else begin
      if (oe_run > 0) begin
        check(oe_run == RD_EXP, "R5 oe_n low width", oe_run, RD_EXP);
        oe_run = 0;
      end
      if (ta_since < 1000) ta_since++;
    end
    if (mem_dq_oe && !p_dq_oe && after_read) begin
      check(ta_since >= TA_EXP, "R6 turnaround gap", ta_since, TA_EXP);
      after_read = 0;
    end
    if (!mem_we_n && p_we) we_falls++;
    if (!mem_ce_n && p_ce_n) sel_falls++;
    if (mem_addr != p_addr && (!p_ce_n || !p_we)) addr_bad++;
    if (rsp_done && p_done) done_bad++;
    if (req_ready && !mem_ce_n) ready_bad++;
    if (mem_dq_oe && !mem_oe_n) cont_bad++;
    p_we = mem_we_n; p_ce_n = mem_ce_n; p_done = rsp_done; p_dq_oe = mem_dq_oe; p_addr = mem_addr;
  end

  task automatic run_req(input logic wr, input logic [16:0] a, input logic [15:0] d,
                         input logic [1:0] m, output logic [15:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = m;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_done) @(negedge clk);
    rd = rsp_rdata;
  endtask

  function automatic logic [16:0] addr_of(input int i);
    return {9'(i * 53 + 1), 8'(i * 17)};
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [15:0] rd;
    for (int i = 0; i < 256; i++) begin
      mdl[i] = 16'(i * 613 + 7);
      expv[i] = 16'(i * 613 + 7);
    end
    repeat (5) @(negedge clk);
    check(req_ready === 1'b1 && rsp_done === 1'b0, "R1 host side idle", {req_ready, rsp_done}, 2'b10);
    check({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n} === 5'b11111, "R1 strobes high",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'b11111);
    check(mem_ce === 1'b0 && mem_dq_oe === 1'b0, "R1 ce and drivers low", {mem_ce, mem_dq_oe}, 0);
    rst_n = 1;

    for (int i = 0; i < 16; i++) begin
      run_req(0, addr_of(i), 16'h0, 2'b11, rd);
      check(rd == expv[8'(i * 17)], "R5 initial read data", rd, expv[8'(i * 17)]);
      check(seen_addr == addr_of(i), "R5 address on pins", seen_addr, addr_of(i));
    end

    for (int i = 0; i < 16; i++) begin
      logic [1:0] m;
      logic [15:0] d;
      logic [7:0] k;
      int wf, sf;
      m = 2'(i % 4);
      d = 16'(16'hC35A ^ (i * 16'h1111));
      k = 8'(i * 17);
      wf = we_falls; sf = sel_falls;
      run_req(1, addr_of(i), d, m, rd);
      if (m[0]) expv[k][7:0] = d[7:0];
      if (m[1]) expv[k][15:8] = d[15:8];
      if (m == 2'b00) begin
        check(we_falls == wf, "R7 no we strobe on empty mask", we_falls - wf, 0);
        check(sel_falls == sf, "R7 no chip select on empty mask", sel_falls - sf, 0);
      end
      run_req(0, addr_of(i), 16'h0, 2'b11, rd);
      check(rd == expv[k], "R2 lane merge readback", rd, expv[k]);
    end

    for (int i = 0; i < 16; i++) begin
      run_req(0, addr_of(i), 16'h0, 2'b11, rd);
      check(rd == expv[8'(i * 17)], "R2 final sweep", rd, expv[8'(i * 17)]);
    end

    repeat (4) @(negedge clk);
    check(drv_bad == 0, "R3 data driven at write end", drv_bad, 0);
    check(addr_bad == 0, "R4 address moved while selected", addr_bad, 0);
    check(done_bad == 0, "R8 done longer than one cycle", done_bad, 0);
    check(ready_bad == 0, "R8 ready while selected", ready_bad, 0);
    check(cont_bad == 0, "R9 drive during output enable", cont_bad, 0);
    finished = 1;
    summary();
  end
endmodule